// File: doc/BRIEF.md
# Serial Result Output Port with Daisy-Chain Tag

This block is the digital side of a converter's serial readout. It keeps the most recent finished 12-bit result in an output register. The register is written when the busy line rises at the end of a conversion. From there the block sends the word out on one serial data line, most significant bit first.

The port has two clock sources, picked by a mode input.

- **Internal source:** a new conversion start (select and read/convert both low) makes the block produce exactly twelve data clock pulses of its own. The previous result is sent on those pulses.
- **External source:** a read trigger first raises a sync flag. The stored word is then shifted by a data clock supplied from outside. The level on a tag input enters behind the word, so it reappears on serial data twelve external clocks later. This lets the results of several chained ports follow one another on a single line.

There is one hazard in external mode. If the external clock is high when busy rises, the new result is lost and the previous word stays in the register.

All inputs are assumed to be synchronous to the system clock. External clock edges are found by sampling at the system clock rate. Each level of the external clock must therefore last at least two system clock cycles.

Top module: `ser_out_port`

## Requirements
- R1: After a synchronous active-low reset, the outputs are as follows:
  - `sdata_en`, `sync` and `dclk_out` are 0.
  - The output register holds zero, so the first internal readout sends twelve 0 bits.
- R2: One cycle after a rising edge of `busy`, the output register holds the 12-bit `result` value. The one exception is the case in R9.
- R3: In internal mode (`ext_mode`=0), the start condition (`sel_n`=0 and `rd_cv`=0) becoming true launches a clock train on `dclk_out`:
  - There are exactly 12 pulses.
  - Each high phase and each low phase lasts `HALF_DIV` system clocks.
  - After the train, `dclk_out` stays low.
- R4: In internal mode, `sdata` carries the output register most significant bit first. Each bit is stable at the rising edge of `dclk_out` and changes only after a falling edge.
- R5: A start condition that becomes true again while an internal train is running is ignored. The train still has 12 pulses and sends the same word.
- R6: In external mode (`ext_mode`=1), the read condition (`sel_n`=0 and `rd_cv`=1) becoming true sets `sync` to 1 on the next cycle. This covers both `rd_cv` rising and `sel_n` falling. `sync` returns to 0 after the first falling edge of `ext_dclk`.
- R7: In external mode, after a read trigger, `sdata` shows the output register most significant bit first. It advances one bit after each falling edge of `ext_dclk`, so each bit is valid while `ext_dclk` is high.
- R8: In external mode, `tag_in` is sampled at each falling edge of `ext_dclk`. The sampled level appears on `sdata` during the high phase after the twelfth following falling edge. Bits 13 to 24 of a readout are therefore the tag levels taken at falling edges 1 to 12.
- R9: In external mode, a rising edge of `busy` while `ext_dclk` is 1 leaves the output register unchanged. The new result is lost.
- R10: `sdata_en` follows these inputs one cycle later:
  - It is 0 whenever `sel_n` is 1.
  - In internal mode it is 1 while `sel_n` is 0.
  - In external mode it is 1 only from a read trigger until `sel_n` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| busy | input | 1 | Conversion busy; rising edge marks a finished result |
| result | input | WORD_W | Result word from the conversion engine |
| ext_mode | input | 1 | 0: internal data clock, 1: external data clock |
| sel_n | input | 1 | Select, active low |
| rd_cv | input | 1 | Read (1) / convert (0) control |
| ext_dclk | input | 1 | Externally supplied data clock |
| tag_in | input | 1 | Daisy-chain tag input |
| sdata | output | 1 | Serial data |
| sdata_en | output | 1 | Serial data drive enable (0 means high impedance) |
| sync | output | 1 | Frame sync flag in external mode |
| dclk_out | output | 1 | Generated data clock in internal mode |

## Verification
Each kind of wrong internal state shows up at the ports:

- **Output register:** a bad load or a missed loss shows up as a wrong bit within the next readout. This is no later than the twelfth data clock, in either mode.
- **Pulse counter or divider:** a fault shows up as a wrong pulse count or a wrong phase width on `dclk_out` during the train it corrupts.
- **Shift chain:** a broken tag stage is only visible twelve external clocks after the tag enters. The bench therefore clocks 24 bits per external readout.
- **Sync and enable flags:** these can be checked within two system clocks of the select and read/convert changes.

// File: rtl/ser_out_pkg.sv
// Shared types and helpers for the serial result output port.
package ser_out_pkg;

    // Source of the data clock used to shift the result out.
    typedef enum logic {
        SRC_INTERNAL = 1'b0,
        SRC_EXTERNAL = 1'b1
    } clk_src_e;

    // True on the cycle a sampled level goes from low to high.
    function automatic logic went_high(input logic now_lvl, input logic prev_lvl);
        return now_lvl & ~prev_lvl;
    endfunction

endpackage

// File: rtl/ser_result_reg.sv
// Output result register.
// Captures the conversion result on a rising edge of busy. In external-clock
// mode a capture that meets a high external data clock is lost and the old
// word is kept.
// Assumes busy and ext_dclk are synchronous to clk.
module ser_result_reg
    import ser_out_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         busy,
    input  clk_src_e     src,
    input  logic         ext_dclk,
    input  logic [W-1:0] result,
    output logic [W-1:0] word_q
);

    logic busy_prev;
    logic busy_rise;
    logic lost;

    assign busy_rise = went_high(busy, busy_prev);
    assign lost      = (src == SRC_EXTERNAL) && ext_dclk;

    // Remember the previous busy level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_prev <= 1'b0;
        else        busy_prev <= busy;
    end

    // Capture a finished result unless the external clock corrupts it.
    always_ff @(posedge clk) begin
        if (!rst_n)                 word_q <= '0;
        else if (busy_rise && !lost) word_q <= result;
    end

    AST_LOAD_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_rise && !lost) |=> (word_q == $past(result)));   // R2
    AST_LOST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_rise && lost) |=> $stable(word_q));              // R9

endmodule

// File: rtl/ser_int_clkgen.sv
// Internal data clock generator.
// On start it produces exactly PULSES pulses. Each level lasts HALF system
// clocks, and the clock starts and ends low. A one-cycle strobe marks every
// falling edge. A start while a train is running is ignored.
module ser_int_clkgen #(
    parameter int HALF   = 4,
    parameter int PULSES = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic dclk,
    output logic fall_stb,
    output logic running
);

    localparam int PH_W  = $clog2(HALF + 1);
    localparam int CNT_W = $clog2(PULSES + 1);

    logic [PH_W-1:0]  phase;
    logic [CNT_W-1:0] pulse_cnt;
    logic             phase_end;
    logic             last_fall;

    assign phase_end = (phase == PH_W'(HALF - 1));
    assign last_fall = phase_end && dclk && (pulse_cnt == CNT_W'(PULSES - 1));
    assign fall_stb  = running && phase_end && dclk;

    // Run/idle state, phase divider, pulse counter and clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running   <= 1'b0;
            phase     <= '0;
            pulse_cnt <= '0;
            dclk      <= 1'b0;
        end else if (!running) begin
            if (start) begin
                running   <= 1'b1;
                phase     <= '0;
                pulse_cnt <= '0;
                dclk      <= 1'b0;
            end
        end else if (phase_end) begin
            phase <= '0;
            dclk  <= ~dclk;
            if (dclk) begin
                pulse_cnt <= pulse_cnt + 1'b1;
                if (last_fall) running <= 1'b0;
            end
        end else begin
            phase <= phase + 1'b1;
        end
    end

    AST_PULSE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (pulse_cnt < CNT_W'(PULSES)));   // R3
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running) |-> !dclk);                   // R3
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (running && start && !last_fall) |=> running); // R5

endmodule

// File: rtl/ser_shift_chain.sv
// Shift chain holding the outgoing word.
// Load copies a parallel word in. Shift moves every stage one place toward
// the MSB and takes shift_in at stage 0, so after the word come the bits
// shifted in behind it. Load has priority over shift.
module ser_shift_chain #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_word,
    input  logic         shift,
    input  logic         shift_in,
    output logic         msb
);

    logic [W-1:0] stage;

    for (genvar i = 0; i < W; i++) begin : g_stage
        logic from_below;
        if (i == 0) begin : g_first
            assign from_below = shift_in;
        end else begin : g_rest
            assign from_below = stage[i-1];
        end

        // One stage: parallel load, or take the bit from the stage below.
        always_ff @(posedge clk) begin
            if (!rst_n)     stage[i] <= 1'b0;
            else if (load)  stage[i] <= load_word[i];
            else if (shift) stage[i] <= from_below;
        end
    end

    assign msb = stage[W-1];

endmodule

// File: rtl/ser_out_port.sv
// Serial result output port (top).
// Internal mode: a new conversion start sends the stored result on a
// self-generated clock train.
// External mode: a read trigger raises sync, then the stored result and the
// delayed tag bits are shifted on falling edges of the external clock.
// Assumes all inputs are synchronous to clk and that ext_dclk levels last
// at least two clk cycles.
module ser_out_port
    import ser_out_pkg::*;
#(
    parameter int WORD_W   = 12,
    parameter int HALF_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic [WORD_W-1:0] result,
    input  logic              ext_mode,
    input  logic              sel_n,
    input  logic              rd_cv,
    input  logic              ext_dclk,
    input  logic              tag_in,
    output logic              sdata,
    output logic              sdata_en,
    output logic              sync,
    output logic              dclk_out
);

    clk_src_e          src;
    logic [WORD_W-1:0] word_q;
    logic              start_cond, read_cond;
    logic              start_prev, read_prev, dclk_prev;
    logic              int_start, ext_trig, ext_fall;
    logic              rd_active;
    logic              int_fall, int_running;
    logic              do_load, do_shift, shift_bit;

    assign src        = clk_src_e'(ext_mode);
    assign start_cond = ~sel_n & ~rd_cv;
    assign read_cond  = ~sel_n & rd_cv;
    assign int_start  = (src == SRC_INTERNAL) && went_high(start_cond, start_prev);
    assign ext_trig   = (src == SRC_EXTERNAL) && went_high(read_cond, read_prev);
    assign ext_fall   = dclk_prev & ~ext_dclk;

    // Previous levels for edge detection of controls and the external clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_prev <= 1'b0;
            read_prev  <= 1'b0;
            dclk_prev  <= 1'b0;
        end else begin
            start_prev <= start_cond;
            read_prev  <= read_cond;
            dclk_prev  <= ext_dclk;
        end
    end

    // External read window: opened by a trigger, closed by deselect.
    always_ff @(posedge clk) begin
        if (!rst_n || sel_n || src == SRC_INTERNAL) rd_active <= 1'b0;
        else if (ext_trig)                          rd_active <= 1'b1;
    end

    // Sync flag: set by a trigger, cleared by the first external falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n || sel_n || src == SRC_INTERNAL) sync <= 1'b0;
        else if (ext_trig)                          sync <= 1'b1;
        else if (ext_fall)                          sync <= 1'b0;
    end

    // Serial data drive enable.
    always_ff @(posedge clk) begin
        if (!rst_n) sdata_en <= 1'b0;
        else        sdata_en <= ~sel_n & ((src == SRC_INTERNAL) | rd_active | ext_trig);
    end

    ser_result_reg #(.W(WORD_W)) i_result (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (busy),
        .src      (src),
        .ext_dclk (ext_dclk),
        .result   (result),
        .word_q   (word_q)
    );

    ser_int_clkgen #(.HALF(HALF_DIV), .PULSES(WORD_W)) i_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (int_start),
        .dclk     (dclk_out),
        .fall_stb (int_fall),
        .running  (int_running)
    );

    assign do_load   = (int_start && !int_running) || ext_trig;
    assign do_shift  = int_fall || (rd_active && ext_fall && src == SRC_EXTERNAL);
    assign shift_bit = (src == SRC_EXTERNAL) ? tag_in : 1'b0;

    ser_shift_chain #(.W(WORD_W)) i_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (do_load),
        .load_word (word_q),
        .shift     (do_shift),
        .shift_in  (shift_bit),
        .msb       (sdata)
    );

    AST_HIZ_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> !sdata_en);                        // R10
    AST_SYNC_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        ext_trig |=> (sync && sdata_en));            // R6
    AST_SYNC_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (sync && ext_fall && !sel_n && ext_mode) |=> !sync); // R6
    AST_DCLK_IDLE_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_running && !int_start) |=> !dclk_out); // R3

endmodule

// File: tb/test_ser_out_port.sv
module test_ser_out_port;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 12;
    localparam int HALF       = 4;
    localparam int WATCHDOG   = 100000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         busy = 1'b0;
    logic [W-1:0] result = '0;
    logic         ext_mode = 1'b0;
    logic         sel_n = 1'b1;
    logic         rd_cv = 1'b1;
    logic         ext_dclk = 1'b0;
    logic         tag_in = 1'b0;
    logic         sdata, sdata_en, sync, dclk_out;

    int checks = 0;
    int fails  = 0;
    int rises  = 0;
    int cycles = 0;
    logic [W-1:0] exp_word = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ser_out_port #(.WORD_W(W), .HALF_DIV(HALF)) i_ser_out_port (
        .clk(clk), .rst_n(rst_n), .busy(busy), .result(result),
        .ext_mode(ext_mode), .sel_n(sel_n), .rd_cv(rd_cv),
        .ext_dclk(ext_dclk), .tag_in(tag_in), .sdata(sdata),
        .sdata_en(sdata_en), .sync(sync), .dclk_out(dclk_out)
    );

    // Count generated clock pulses.
    always @(posedge dclk_out) rises++;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Expected register after a capture (R2, R9).
    function automatic logic [W-1:0] after_capture(input logic [W-1:0] old_w,
            input logic [W-1:0] new_w, input logic ext, input logic dclk_lvl);
        return (ext && dclk_lvl) ? old_w : new_w;
    endfunction

    // Expected serial bit j (1-based) of an external readout (R7, R8).
    function automatic logic ext_bit(input logic [W-1:0] w, input logic [2*W:1] tags, input int j);
        return (j <= W) ? w[W-j] : tags[j-W];
    endfunction

    task automatic capture(input logic [W-1:0] w, input logic dclk_lvl);
        @(negedge clk);
        result = w;
        ext_dclk = dclk_lvl;
        @(negedge clk);
        busy = 1'b1;
        repeat (2) @(negedge clk);
        busy = 1'b0;
        ext_dclk = 1'b0;
        exp_word = after_capture(exp_word, w, ext_mode, dclk_lvl);
        repeat (2) @(negedge clk);
    endtask

    task automatic int_read(input bit retrig);
        int base;
        int width;
        base = rises;
        @(negedge clk);
        sel_n = 1'b0;
        rd_cv = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 int enable", sdata_en, 1);
        for (int b = 0; b < W; b++) begin
            @(posedge dclk_out);
            #1;
            check("R4 int bit", sdata, exp_word[W-1-b]);
            if (b == 0) begin
                width = 0;
                while (dclk_out) begin
                    @(posedge clk);
                    #1;
                    width++;
                end
                check("R3 high width", width, HALF);
            end
            if (retrig && b == 3) begin
                @(negedge clk);
                rd_cv = 1'b1;
                @(negedge clk);
                rd_cv = 1'b0;
            end
        end
        repeat (6*HALF) @(negedge clk);
        check(retrig ? "R5 pulses after retrigger" : "R3 pulse count", rises - base, W);
        check("R3 idle low", dclk_out, 0);
        sel_n = 1'b1;
        rd_cv = 1'b1;
        repeat (2) @(negedge clk);
        check("R10 deselect", sdata_en, 0);
    endtask

    task automatic ext_read(input bit via_sel);
        logic [2*W:1] tags;
        tags = '0;
        @(negedge clk);
        if (via_sel) begin
            rd_cv = 1'b1;
            repeat (2) @(negedge clk);
            sel_n = 1'b0;
        end else begin
            rd_cv = 1'b0;
            @(negedge clk);
            sel_n = 1'b0;
            repeat (2) @(negedge clk);
            check("R10 ext no trigger", sdata_en, 0);
            rd_cv = 1'b1;
        end
        repeat (2) @(negedge clk);
        check("R6 sync raised", sync, 1);
        check("R10 ext enable", sdata_en, 1);
        for (int j = 1; j <= 2*W; j++) begin
            ext_dclk = 1'b1;
            repeat (3) @(negedge clk);
            check(j <= W ? "R7 ext bit" : "R8 tag bit", sdata, ext_bit(exp_word, tags, j));
            tag_in = 1'($urandom % 2);
            tags[j] = tag_in;
            ext_dclk = 1'b0;
            repeat (3) @(negedge clk);
            if (j == 1) check("R6 sync cleared", sync, 0);
        end
        sel_n = 1'b1;
        rd_cv = 1'b1;
        repeat (2) @(negedge clk);
        check("R10 ext deselect", sdata_en, 0);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 sdata_en", sdata_en, 0);
        check("R1 sync", sync, 0);
        check("R1 dclk_out", dclk_out, 0);
        int_read(1'b0);                      // R1: zeros after reset

        capture(12'hA5C, 1'b0);              // R2
        int_read(1'b1);                      // R4, R5
        capture(12'h35A, 1'b1);              // R2: internal mode ignores ext_dclk
        int_read(1'b0);

        ext_mode = 1'b1;
        capture(12'h3F0, 1'b0);              // R2
        ext_read(1'b0);                      // R6, R7, R8
        capture(12'hFFF, 1'b1);              // R9: lost
        ext_read(1'b1);                      // shows 3F0
        check("R9 kept word", exp_word, 12'h3F0);

        for (int n = 0; n < 10; n++) begin
            ext_mode = 1'($urandom % 2);
            capture(W'($urandom), 1'($urandom % 2));
            if (ext_mode) ext_read(1'($urandom % 2));
            else          int_read(1'($urandom % 2));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule